// File: doc/BRIEF.md
# Configuration DMA Command Front End

This block is the register-facing half of a DMA engine that streams a configuration image from memory into a device configuration port. Software stages a transfer by writing four registers: where the data comes from, where (if anywhere) it goes in memory, and how many 32-bit words move on each side. Writing the destination word count, which must be the last of the four writes, turns the staged values into one command and places it in a small first-in, first-out command queue.

The queue feeds a data mover through a valid/ready command interface, one command in flight at a time. The mover reports the end of each transfer with a pulse. A command whose source address has bit 0 set is the final transfer of an image. Its completion is held back until the configuration port reports that it has drained. Completion, queue overflow and malformed commands are reported as single-cycle event pulses on fixed bit positions, to be picked up by a neighbouring interrupt unit. Queue full and empty are driven as live status bits.

Top module: `cfgdma_front`

## Requirements
- R1: After reset, the status word shows the queue empty (bit 30 = 1) and not full (bit 31 = 0), `cmd_valid` is low and every event bit is 0.
- R2: Writes land at offsets 0x018 (source address), 0x01C (destination address), 0x020 (source length) and 0x024 (destination length). Only a write to 0x024 submits a command, and it uses the most recently staged values of the other three. Writes to other offsets change nothing visible, and staged values persist across submissions.
- R3: Both word counts keep only their low 27 bits, so a written 0xFFFFFFFF becomes 0x7FFFFFF. The zero test of R8 applies to the masked value.
- R4: Bit 0 of the staged source address is presented as `cmd_last`. `cmd_src_addr` carries the address with bit 0 cleared.
- R5: `cmd_no_dst` is 1 exactly when the staged destination address is 0xFFFFFFFF. `cmd_dst_addr` always carries the staged value.
- R6: The queue holds 4 commands and issues them in submission order. Status bit 31 is high while 4 are held, and status bit 30 is high while none are held.
- R7: A submission while the queue is full is dropped, leaving the queue unchanged. It pulses event bit 14 for one cycle, in the cycle after the write.
- R8: A submission whose source and destination word counts are both zero is rejected and not queued. It pulses event bit 15 for one cycle, in the cycle after the write. A zero source count with a nonzero destination count is accepted.
- R9: `cmd_valid` is high only while the queue is non-empty and no command is in flight. While it waits for `mv_ready`, the payload is held stable. After a handshake it stays low until that command completes.
- R10: For a command without the last flag, event bit 13 pulses for one cycle, in the cycle after the clock edge that samples `mv_done` high.
- R11: For a command with the last flag, `mv_done` starts a wait. Event bit 13 pulses in the cycle after the first later edge that samples `port_idle` high. No further command is issued before that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write data |
| stat_word | output | 32 | Bit 31 queue full, bit 30 queue empty, others 0 |
| irq_events | output | 32 | One-cycle pulses: bit 13 done, bit 14 overflow, bit 15 command error |
| cmd_valid | output | 1 | Command offered to the mover |
| mv_ready | input | 1 | Mover accepts the offered command |
| cmd_src_addr | output | 32 | Source address, bit 0 cleared |
| cmd_last | output | 1 | Final transfer of an image |
| cmd_dst_addr | output | 32 | Destination address as staged |
| cmd_no_dst | output | 1 | No memory destination |
| cmd_src_len | output | 27 | Source word count |
| cmd_dst_len | output | 27 | Destination word count |
| mv_done | input | 1 | Pulse: mover finished the command in flight |
| port_idle | input | 1 | Configuration port has drained |

## Verification
The assertions assume that the mover pulses `mv_done` exactly once per accepted command and only while that command is in flight. They also assume that `port_idle` is raised only while a final transfer waits for the port to drain, and that no register write occurs during reset. The stimulus respects this. It raises `mv_ready` for a single edge when a command is offered, and it pulses `mv_done` only after that handshake. It drives `port_idle` only during the drain wait that follows a final command's `mv_done`.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    localparam int REG_OFF_W = 12;

    // Register offsets; the destination length offset is the submit trigger.
    localparam logic [REG_OFF_W-1:0] OFS_SRC_ADDR = 12'h018;
    localparam logic [REG_OFF_W-1:0] OFS_DST_ADDR = 12'h01C;
    localparam logic [REG_OFF_W-1:0] OFS_SRC_LEN  = 12'h020;
    localparam logic [REG_OFF_W-1:0] OFS_DST_LEN  = 12'h024;

    // Bit positions decoded by the interrupt unit and status readers.
    localparam int EV_DONE_BIT   = 13;
    localparam int EV_QOVF_BIT   = 14;
    localparam int EV_CMDERR_BIT = 15;
    localparam int ST_QEMPTY_BIT = 30;
    localparam int ST_QFULL_BIT  = 31;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_BUSY  = 2'd1,
        TRK_DRAIN = 2'd2
    } trk_state_e;

endpackage

// File: rtl/cfgdma_stage.sv
module cfgdma_stage
    import cfgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 27,
    localparam int CMD_W = 2*DATA_W + 2*LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_OFF_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 q_full,
    output logic                 push_o,
    output logic [CMD_W-1:0]     push_cmd_o,
    output logic                 ev_qovf_o,
    output logic                 ev_cmderr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [LEN_W-1:0]  slen;
        logic              qovf;
        logic              cmderr;
    } stage_t;

    stage_t s_d, s_q;
    logic   push_d;
    logic [LEN_W-1:0] dlen_w;

    assign dlen_w = wr_data[LEN_W-1:0];

    always_comb begin
        s_d        = s_q;
        s_d.qovf   = 1'b0;
        s_d.cmderr = 1'b0;
        push_d     = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                OFS_SRC_ADDR: s_d.src  = wr_data;
                OFS_DST_ADDR: s_d.dst  = wr_data;
                OFS_SRC_LEN:  s_d.slen = wr_data[LEN_W-1:0];
                OFS_DST_LEN: begin
                    // Malformed commands are rejected before the space check.
                    if (s_q.slen == '0 && dlen_w == '0)
                        s_d.cmderr = 1'b1;
                    else if (q_full)
                        s_d.qovf = 1'b1;
                    else
                        push_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push_o      = push_d;
    assign push_cmd_o  = {s_q.src, s_q.dst, s_q.slen, dlen_w};
    assign ev_qovf_o   = s_q.qovf;
    assign ev_cmderr_o = s_q.cmderr;

endmodule

// File: rtl/cfgdma_cmdq.sv
module cfgdma_cmdq #(
    parameter int W     = 118,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wptr;
        logic [PTR_W-1:0]        rptr;
        logic [CNT_W-1:0]        cnt;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push_i) begin
            q_d.mem[q_q.wptr] = push_data_i;
            q_d.wptr          = step(q_q.wptr);
        end
        if (pop_i)
            q_d.rptr = step(q_q.rptr);
        case ({push_i, pop_i})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.mem[q_q.rptr];
    assign full_o  = (q_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (q_q.cnt == '0);

endmodule

// File: rtl/cfgdma_track.sv
module cfgdma_track
    import cfgdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_empty,
    input  logic head_last,
    input  logic mv_ready,
    input  logic mv_done,
    input  logic port_idle,
    output logic pop_o,
    output logic cmd_valid_o,
    output logic ev_done_o
);

    typedef struct packed {
        trk_state_e st;
        logic       last;
        logic       done;
    } trk_t;

    trk_t t_d, t_q;

    assign cmd_valid_o = (t_q.st == TRK_IDLE) && !q_empty;
    assign pop_o       = cmd_valid_o && mv_ready;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        case (t_q.st)
            TRK_IDLE: if (pop_o) begin
                t_d.st   = TRK_BUSY;
                t_d.last = head_last;
            end
            TRK_BUSY: if (mv_done) begin
                if (t_q.last) begin
                    t_d.st = TRK_DRAIN;
                end else begin
                    t_d.st   = TRK_IDLE;
                    t_d.done = 1'b1;
                end
            end
            TRK_DRAIN: if (port_idle) begin
                t_d.st   = TRK_IDLE;
                t_d.done = 1'b1;
            end
            default: t_d.st = TRK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '{st: TRK_IDLE, last: 1'b0, done: 1'b0};
        else        t_q <= t_d;
    end

    assign ev_done_o = t_q.done;

endmodule

// File: rtl/cfgdma_front.sv
module cfgdma_front
    import cfgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 27,
    parameter int QDEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_OFF_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [31:0]          stat_word,
    output logic [31:0]          irq_events,
    output logic                 cmd_valid,
    input  logic                 mv_ready,
    output logic [DATA_W-1:0]    cmd_src_addr,
    output logic                 cmd_last,
    output logic [DATA_W-1:0]    cmd_dst_addr,
    output logic                 cmd_no_dst,
    output logic [LEN_W-1:0]     cmd_src_len,
    output logic [LEN_W-1:0]     cmd_dst_len,
    input  logic                 mv_done,
    input  logic                 port_idle
);

    localparam int CMD_W = 2*DATA_W + 2*LEN_W;

    logic             push, pop, q_full, q_empty;
    logic             ev_qovf, ev_cmderr, ev_done;
    logic [CMD_W-1:0] push_cmd, head;
    logic [DATA_W-1:0] head_src, head_dst;
    logic [LEN_W-1:0]  head_slen, head_dlen;

    cfgdma_stage #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .q_full      (q_full),
        .push_o      (push),
        .push_cmd_o  (push_cmd),
        .ev_qovf_o   (ev_qovf),
        .ev_cmderr_o (ev_cmderr)
    );

    cfgdma_cmdq #(.W(CMD_W), .DEPTH(QDEPTH)) u_cmdq (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_cmd),
        .pop_i       (pop),
        .head_o      (head),
        .full_o      (q_full),
        .empty_o     (q_empty)
    );

    assign {head_src, head_dst, head_slen, head_dlen} = head;

    cfgdma_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .head_last   (head_src[0]),
        .mv_ready    (mv_ready),
        .mv_done     (mv_done),
        .port_idle   (port_idle),
        .pop_o       (pop),
        .cmd_valid_o (cmd_valid),
        .ev_done_o   (ev_done)
    );

    assign cmd_src_addr = {head_src[DATA_W-1:1], 1'b0};
    assign cmd_last     = head_src[0];
    assign cmd_dst_addr = head_dst;
    assign cmd_no_dst   = &head_dst;
    assign cmd_src_len  = head_slen;
    assign cmd_dst_len  = head_dlen;

    always_comb begin
        stat_word                = '0;
        stat_word[ST_QFULL_BIT]  = q_full;
        stat_word[ST_QEMPTY_BIT] = q_empty;
        irq_events                = '0;
        irq_events[EV_DONE_BIT]   = ev_done;
        irq_events[EV_QOVF_BIT]   = ev_qovf;
        irq_events[EV_CMDERR_BIT] = ev_cmderr;
    end

endmodule

// File: rtl/cfgdma_front_chk.sv
module cfgdma_front_chk
    import cfgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 27
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [REG_OFF_W-1:0] wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [31:0]          stat_word,
    input logic [31:0]          irq_events,
    input logic                 cmd_valid,
    input logic                 mv_ready,
    input logic [DATA_W-1:0]    cmd_src_addr,
    input logic [LEN_W-1:0]     cmd_src_len,
    input logic                 mv_done,
    input logic                 port_idle
);

    localparam logic [DATA_W-1:0] LEN_MASK = DATA_W'((64'd1 << LEN_W) - 1);

    logic dlen_wr, dlen_zero;
    assign dlen_wr   = wr_en && (wr_addr == OFS_DST_LEN);
    assign dlen_zero = (wr_data & LEN_MASK) == '0;

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_word[ST_QFULL_BIT] && stat_word[ST_QEMPTY_BIT]));

    a_r9_valid_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !stat_word[ST_QEMPTY_BIT]);

    a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mv_ready) |=> (cmd_valid && $stable(cmd_src_addr) && $stable(cmd_src_len)));

    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_events[EV_QOVF_BIT] |-> $past(dlen_wr && stat_word[ST_QFULL_BIT]));

    a_r8_cmderr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_events[EV_CMDERR_BIT] |-> $past(dlen_wr && dlen_zero));

    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_events[EV_CMDERR_BIT] && irq_events[EV_QOVF_BIT]));

    a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_events[EV_DONE_BIT] |-> $past(mv_done || port_idle));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_events[EV_DONE_BIT] |=> !irq_events[EV_DONE_BIT]);

endmodule

bind cfgdma_front cfgdma_front_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .stat_word    (stat_word),
    .irq_events   (irq_events),
    .cmd_valid    (cmd_valid),
    .mv_ready     (mv_ready),
    .cmd_src_addr (cmd_src_addr),
    .cmd_src_len  (cmd_src_len),
    .mv_done      (mv_done),
    .port_idle    (port_idle)
);

// File: tb/cfgdma_front_bench.sv
module cfgdma_front_bench;
    import cfgdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] stat_word, irq_events;
    logic        cmd_valid, cmd_last, cmd_no_dst;
    logic        mv_ready = 1'b0, mv_done = 1'b0, port_idle = 1'b0;
    logic [31:0] cmd_src_addr, cmd_dst_addr;
    logic [26:0] cmd_src_len, cmd_dst_len;

    always #10 clk = ~clk;

    cfgdma_front u_cfgdma_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_word(stat_word), .irq_events(irq_events), .cmd_valid(cmd_valid),
        .mv_ready(mv_ready), .cmd_src_addr(cmd_src_addr), .cmd_last(cmd_last),
        .cmd_dst_addr(cmd_dst_addr), .cmd_no_dst(cmd_no_dst), .cmd_src_len(cmd_src_len),
        .cmd_dst_len(cmd_dst_len), .mv_done(mv_done), .port_idle(port_idle)
    );

    typedef struct {
        logic [31:0] src;
        logic [31:0] dst;
        logic [26:0] slen;
        logic [26:0] dlen;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_cmd(logic [31:0] s, logic [31:0] d, logic [31:0] sl, logic [31:0] dl);
        exp_t e;
        e.src = s; e.dst = d; e.slen = sl[26:0]; e.dlen = dl[26:0];
        exp_q.push_back(e);
    endtask

    task automatic serve(bit last);
        mv_ready = 1'b1;
        @(posedge clk); #1;
        mv_ready = 1'b0;
        chk("R9", "valid low while in flight", cmd_valid, 0);
        mv_done = 1'b1;
        @(posedge clk); #1;
        mv_done = 1'b0;
        if (!last) begin
            chk("R10", "done pulse after mover done", irq_events[EV_DONE_BIT], 1);
            @(posedge clk); #1;
            chk("R10", "done pulse is one cycle", irq_events[EV_DONE_BIT], 0);
        end else begin
            chk("R11", "no done before drain", irq_events[EV_DONE_BIT], 0);
            for (int i = 0; i < 3; i++) begin
                @(posedge clk); #1;
                chk("R11", "still waiting for port", irq_events[EV_DONE_BIT], 0);
                chk("R11", "no issue during drain", cmd_valid, 0);
            end
            port_idle = 1'b1;
            @(posedge clk); #1;
            port_idle = 1'b0;
            chk("R11", "done after port drained", irq_events[EV_DONE_BIT], 1);
        end
    endtask

    // Monitor: compares each accepted command with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && cmd_valid && mv_ready) begin
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected command", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2", "src addr", cmd_src_addr, {e.src[31:1], 1'b0});
                chk("R4", "last flag", cmd_last, e.src[0]);
                chk("R5", "dst addr", cmd_dst_addr, e.dst);
                chk("R5", "no-dst flag", cmd_no_dst, (e.dst == 32'hFFFF_FFFF));
                chk("R3", "src len", cmd_src_len, e.slen);
                chk("R3", "dst len", cmd_dst_len, e.dlen);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "empty after reset", stat_word[ST_QEMPTY_BIT], 1);
        chk("R1", "not full after reset", stat_word[ST_QFULL_BIT], 0);
        chk("R1", "no valid after reset", cmd_valid, 0);
        chk("R1", "no events after reset", irq_events, 0);

        // R2: staging and unmapped writes do not submit
        reg_wr(OFS_SRC_ADDR, 32'h0000_1000);
        reg_wr(12'h028, 32'h1234_5678);
        chk("R2", "no submit without trigger", stat_word[ST_QEMPTY_BIT], 1);
        chk("R2", "no valid without trigger", cmd_valid, 0);

        // Command A: no destination, masked length
        reg_wr(OFS_DST_ADDR, 32'hFFFF_FFFF);
        reg_wr(OFS_SRC_LEN, 32'hFFFF_FFFF);
        expect_cmd(32'h0000_1000, 32'hFFFF_FFFF, 32'h07FF_FFFF, 0);
        reg_wr(OFS_DST_LEN, 32'h0);
        chk("R6", "not empty after submit", stat_word[ST_QEMPTY_BIT], 0);
        chk("R9", "valid after submit", cmd_valid, 1);
        repeat (2) @(posedge clk);
        #1 chk("R9", "valid held without ready", cmd_valid, 1);

        // Command B: last flag
        reg_wr(OFS_SRC_ADDR, 32'h0000_2001);
        reg_wr(OFS_DST_ADDR, 32'h0000_8000);
        reg_wr(OFS_SRC_LEN, 32'h10);
        expect_cmd(32'h0000_2001, 32'h0000_8000, 32'h10, 32'h10);
        reg_wr(OFS_DST_LEN, 32'h10);

        // Command C and D: D reuses C's staged values
        reg_wr(OFS_SRC_ADDR, 32'h0000_3000);
        reg_wr(OFS_DST_ADDR, 32'h0000_9000);
        reg_wr(OFS_SRC_LEN, 32'h4);
        expect_cmd(32'h0000_3000, 32'h0000_9000, 32'h4, 32'h0);
        reg_wr(OFS_DST_LEN, 32'h0);
        chk("R6", "not full at three", stat_word[ST_QFULL_BIT], 0);
        expect_cmd(32'h0000_3000, 32'h0000_9000, 32'h4, 32'h7);
        reg_wr(OFS_DST_LEN, 32'h7);
        chk("R6", "full at four", stat_word[ST_QFULL_BIT], 1);

        // R7: overflow
        reg_wr(OFS_DST_LEN, 32'h9);
        chk("R7", "overflow pulse", irq_events[EV_QOVF_BIT], 1);
        chk("R7", "no error on overflow", irq_events[EV_CMDERR_BIT], 0);
        @(posedge clk); #1;
        chk("R7", "overflow pulse one cycle", irq_events[EV_QOVF_BIT], 0);
        chk("R7", "still full", stat_word[ST_QFULL_BIT], 1);

        serve(1'b0);
        chk("R6", "not full after one issued", stat_word[ST_QFULL_BIT], 0);
        serve(1'b1);
        serve(1'b0);
        serve(1'b0);
        chk("R6", "empty after drain", stat_word[ST_QEMPTY_BIT], 1);

        // R8: zero-length rejection, including masked-to-zero length
        reg_wr(OFS_SRC_LEN, 32'h0);
        reg_wr(OFS_DST_LEN, 32'h0);
        chk("R8", "error pulse", irq_events[EV_CMDERR_BIT], 1);
        chk("R8", "no overflow on error", irq_events[EV_QOVF_BIT], 0);
        @(posedge clk); #1;
        chk("R8", "error pulse one cycle", irq_events[EV_CMDERR_BIT], 0);
        chk("R8", "rejected not queued", stat_word[ST_QEMPTY_BIT], 1);
        reg_wr(OFS_DST_LEN, 32'h0800_0000);
        chk("R3", "masked zero length rejected", irq_events[EV_CMDERR_BIT], 1);
        chk("R8", "masked reject not queued", stat_word[ST_QEMPTY_BIT], 1);

        expect_cmd(32'h0000_3000, 32'h0000_9000, 32'h0, 32'h5);
        reg_wr(OFS_DST_LEN, 32'h5);
        chk("R8", "zero source with dst accepted", stat_word[ST_QEMPTY_BIT], 0);
        chk("R8", "no error when accepted", irq_events[EV_CMDERR_BIT], 0);
        serve(1'b0);

        chk("R6", "all commands issued in order", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule